// File: doc/BRIEF.md
# Bus-Cycle Fault Capture Register

This block collects error reports from the system bus into one 16-bit sticky status word. Three active-low level inputs (memory protection, memory parity and external address) are sampled once per bus cycle. Sampling happens at the end of the cycle, when the active-low bus busy line returns high. Every bus cycle is watched, whether the processor drives it or another master does. The bit each report sets depends on what kind of cycle it was. The block records who owns the cycle and whether it targets memory or I/O at the moment busy first goes low, and keeps that for the rest of the cycle.

Two further fault inputs are asynchronous and respond to rising edges. Each passes through a flop synchronizer and an edge detector before it sets its bits. The word holds every captured bit until software pulses a clear strobe. A summary flag goes high whenever any bit is set. Bit numbering follows a most-significant-first convention: numbered bit n sits at vector index 15-n.

Top module: `fault_capture_reg`

## Requirements
- R1: After synchronous reset, `flt_word` is 16'h0000 and `flt_any` is 0.
- R2: A bus cycle starts at the first clock edge that samples `bus_busy_n` low after it was high. It ends at the first edge that samples it high again. The level fault inputs are sampled only at that ending edge, so a fault that is asserted and then removed before the ending edge sets nothing.
- R3: `prot_err_n` low at the ending edge sets numbered bit 0 (vector index 15) on a processor-owned cycle (`cyc_own`=1). On a cycle owned by another master it sets numbered bit 1 (index 14).
- R4: `par_err_n` low at the ending edge sets numbered bit 2 (index 13), whatever the cycle type.
- R5: `addr_err_n` low at the ending edge sets numbered bit 5 (index 10) on a memory cycle (`cyc_mem`=1). On an I/O cycle it sets numbered bit 8 (index 7).
- R6: The ownership and memory/I/O type that choose bit positions are those sampled at the starting edge of the cycle. Changes on `cyc_own` and `cyc_mem` later in the cycle have no effect on which bits are set.
- R7: A rising edge on `sys_flt0` sets numbered bit 7 (index 8). The bit appears after the third rising clock edge, counting the first edge that samples the input high. A level held high does not set the bit again once it has been cleared.
- R8: A rising edge on `sys_flt1` sets numbered bits 13 and 15 (indices 2 and 0) together, with the same latency as R7.
- R9: Set bits are sticky: captures accumulate by OR. A `clr_stb` pulse sampled at a clock edge zeroes the word at that edge.
- R10: When a clear and a capture fall on the same edge, the word holds exactly the newly captured bits after that edge.
- R11: `flt_any` is 1 exactly when `flt_word` is nonzero, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_busy_n | input | 1 | Active-low bus busy; low for the length of a bus cycle |
| cyc_own | input | 1 | 1 = processor owns the cycle, 0 = another master |
| cyc_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| prot_err_n | input | 1 | Active-low memory protection error |
| par_err_n | input | 1 | Active-low memory parity error |
| addr_err_n | input | 1 | Active-low external address error |
| sys_flt0 | input | 1 | Asynchronous rising-edge system fault 0 |
| sys_flt1 | input | 1 | Asynchronous rising-edge system fault 1 |
| clr_stb | input | 1 | Software clear strobe, one clock wide |
| flt_word | output | 16 | Sticky fault word, vector index 15-n holds numbered bit n |
| flt_any | output | 1 | High when any fault bit is set |

## Verification
The assertions assume two things about the bus. First, `bus_busy_n` stays low for at least one sampled clock, so that a cycle type is always latched before the ending edge. Second, level faults are stable at the edge where busy returns high. The bench meets both assumptions. It changes every input only on falling clock edges and holds each bus cycle low for two clocks. It flips `cyc_own` and `cyc_mem` mid-cycle to show that only the start-of-cycle values matter. The asynchronous fault inputs are held high for several clocks, so the synchronizer always sees a clean edge.

// File: rtl/fault_pkg.sv
package fault_pkg;
  localparam int FLT_W = 16;

  // Numbered positions, bit 0 = most significant
  localparam int NB_PROT_OWN   = 0;
  localparam int NB_PROT_OTHER = 1;
  localparam int NB_PARITY     = 2;
  localparam int NB_ADDR_MEM   = 5;
  localparam int NB_SYS0       = 7;
  localparam int NB_ADDR_IO    = 8;
  localparam int NB_SYS1_LO    = 13;
  localparam int NB_SYS1_HI    = 15;

  localparam int NUM_ASYNC = 2;

  function automatic int vpos(input int numbered);
    return FLT_W - 1 - numbered;
  endfunction
endpackage

// File: rtl/flt_edge_sync.sv
module flt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_pulse
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  // newest synchronized sample high, previous one low
  assign rise_pulse = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/flt_bus_track.sv
module flt_bus_track (
  input  logic clk,
  input  logic rst,
  input  logic busy_n,
  input  logic own_in,
  input  logic mem_in,
  output logic cyc_end,
  output logic own_lat,
  output logic mem_lat
);
  logic busy_q;
  logic cyc_start;

  assign cyc_start = busy_q & ~busy_n;
  assign cyc_end   = ~busy_q & busy_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b1;
      own_lat <= 1'b0;
      mem_lat <= 1'b0;
    end else begin
      busy_q <= busy_n;
      if (cyc_start) begin
        own_lat <= own_in;
        mem_lat <= mem_in;
      end
    end
  end
endmodule

// File: rtl/fault_capture_reg.sv
module fault_capture_reg
  import fault_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_busy_n,
  input  logic             cyc_own,
  input  logic             cyc_mem,
  input  logic             prot_err_n,
  input  logic             par_err_n,
  input  logic             addr_err_n,
  input  logic             sys_flt0,
  input  logic             sys_flt1,
  input  logic             clr_stb,
  output logic [FLT_W-1:0] flt_word,
  output logic             flt_any
);
  logic                 cyc_end;
  logic                 own_lat;
  logic                 mem_lat;
  logic [NUM_ASYNC-1:0] async_in;
  logic [NUM_ASYNC-1:0] async_rise;
  logic [FLT_W-1:0]     set_vec;
  logic [FLT_W-1:0]     nxt_word;

  flt_bus_track u_track (
    .clk     (clk),
    .rst     (rst),
    .busy_n  (bus_busy_n),
    .own_in  (cyc_own),
    .mem_in  (cyc_mem),
    .cyc_end (cyc_end),
    .own_lat (own_lat),
    .mem_lat (mem_lat)
  );

  assign async_in = {sys_flt1, sys_flt0};

  for (genvar g = 0; g < NUM_ASYNC; g++) begin : g_sync
    flt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst        (rst),
      .async_in   (async_in[g]),
      .rise_pulse (async_rise[g])
    );
  end

  always_comb begin
    set_vec = '0;
    if (cyc_end) begin
      if (!prot_err_n) begin
        if (own_lat) set_vec[vpos(NB_PROT_OWN)]   = 1'b1;
        else         set_vec[vpos(NB_PROT_OTHER)] = 1'b1;
      end
      if (!par_err_n) set_vec[vpos(NB_PARITY)] = 1'b1;
      if (!addr_err_n) begin
        if (mem_lat) set_vec[vpos(NB_ADDR_MEM)] = 1'b1;
        else         set_vec[vpos(NB_ADDR_IO)]  = 1'b1;
      end
    end
    if (async_rise[0]) set_vec[vpos(NB_SYS0)] = 1'b1;
    if (async_rise[1]) begin
      set_vec[vpos(NB_SYS1_LO)] = 1'b1;
      set_vec[vpos(NB_SYS1_HI)] = 1'b1;
    end
  end

  // capture wins over clear on the same edge
  assign nxt_word = (clr_stb ? '0 : flt_word) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      flt_word <= '0;
      flt_any  <= 1'b0;
    end else begin
      flt_word <= nxt_word;
      flt_any  <= |nxt_word;
    end
  end
endmodule

// File: rtl/fault_capture_reg_chk.sv
module fault_capture_reg_chk
  import fault_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             bus_busy_n,
  input logic             clr_stb,
  input logic [FLT_W-1:0] flt_word,
  input logic             flt_any
);
  localparam logic [FLT_W-1:0] LVL_MASK =
    (FLT_W'(1) << vpos(NB_PROT_OWN))   | (FLT_W'(1) << vpos(NB_PROT_OTHER)) |
    (FLT_W'(1) << vpos(NB_PARITY))     | (FLT_W'(1) << vpos(NB_ADDR_MEM))   |
    (FLT_W'(1) << vpos(NB_ADDR_IO));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !clr_stb |=> ((flt_word & $past(flt_word)) == $past(flt_word)));

  assert_summary_R11: assert property (@(posedge clk) disable iff (rst)
    flt_any == (flt_word != '0));

  assert_level_at_end_R2: assert property (@(posedge clk) disable iff (rst)
    ((flt_word & ~$past(flt_word) & LVL_MASK) != '0)
      |-> ($past(bus_busy_n) && !$past(bus_busy_n, 2)));

  assert_pair_R8: assert property (@(posedge clk) disable iff (rst)
    flt_word[vpos(NB_SYS1_LO)] == flt_word[vpos(NB_SYS1_HI)]);
endmodule

bind fault_capture_reg fault_capture_reg_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_busy_n (bus_busy_n),
  .clr_stb    (clr_stb),
  .flt_word   (flt_word),
  .flt_any    (flt_any)
);

// File: tb/fault_capture_reg_tb_top.sv
module fault_capture_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_busy_n = 1'b1;
  logic        cyc_own = 1'b0;
  logic        cyc_mem = 1'b0;
  logic        prot_err_n = 1'b1;
  logic        par_err_n = 1'b1;
  logic        addr_err_n = 1'b1;
  logic        sys_flt0 = 1'b0;
  logic        sys_flt1 = 1'b0;
  logic        clr_stb = 1'b0;
  logic [15:0] flt_word;
  logic        flt_any;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fault_capture_reg dut_i (
    .clk(clk), .rst(rst), .bus_busy_n(bus_busy_n), .cyc_own(cyc_own),
    .cyc_mem(cyc_mem), .prot_err_n(prot_err_n), .par_err_n(par_err_n),
    .addr_err_n(addr_err_n), .sys_flt0(sys_flt0), .sys_flt1(sys_flt1),
    .clr_stb(clr_stb), .flt_word(flt_word), .flt_any(flt_any)
  );

  function automatic logic [15:0] nb(input int n);
    return 16'h0001 << (15 - n);
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    n_checks++;
    if (flt_word !== exp) begin
      n_fails++;
      $display("FAIL %s word: actual %h expected %h", req, flt_word, exp);
    end
    n_checks++;
    if (flt_any !== (exp != 16'h0)) begin
      n_fails++;
      $display("FAIL R11 summary (%s): actual %b expected %b", req, flt_any, exp != 16'h0);
    end
  endtask

  task automatic do_clear();
    @(negedge clk) clr_stb = 1'b1;
    @(negedge clk) clr_stb = 1'b0;
    check("R9 clear", 16'h0);
  endtask

  // one bus cycle; type flipped mid-cycle; faults optionally dropped before end
  task automatic bus_cycle(input bit own, input bit mem, input bit prot, input bit par,
                           input bit adr, input bit drop_early, input bit clr_end);
    @(negedge clk);
    bus_busy_n = 1'b0; cyc_own = own; cyc_mem = mem;
    @(negedge clk);
    cyc_own = ~own; cyc_mem = ~mem;
    prot_err_n = ~prot; par_err_n = ~par; addr_err_n = ~adr;
    @(negedge clk);
    bus_busy_n = 1'b1; clr_stb = clr_end;
    if (drop_early) begin
      prot_err_n = 1'b1; par_err_n = 1'b1; addr_err_n = 1'b1;
    end
    @(negedge clk);
    clr_stb = 1'b0; prot_err_n = 1'b1; par_err_n = 1'b1; addr_err_n = 1'b1;
  endtask

  function automatic logic [15:0] lvl_exp(input bit own, input bit mem, input bit prot,
                                          input bit par, input bit adr);
    logic [15:0] e = 16'h0;
    if (prot) e |= own ? nb(0) : nb(1);
    if (par)  e |= nb(2);
    if (adr)  e |= mem ? nb(5) : nb(8);
    return e;
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset", 16'h0);

    // R3 R4 R5 R6: exhaustive sweep of type and fault combinations
    for (int v = 0; v < 32; v++) begin
      bus_cycle(v[0], v[1], v[2], v[3], v[4], 1'b0, 1'b0);
      check("R3/R4/R5/R6 sweep", lvl_exp(v[0], v[1], v[2], v[3], v[4]));
      do_clear();
    end

    // R2: faults removed before the ending edge are ignored
    bus_cycle(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R2 early drop", 16'h0);
    // R2: fault with busy idle is ignored
    @(negedge clk) prot_err_n = 1'b0; par_err_n = 1'b0;
    repeat (3) @(negedge clk);
    prot_err_n = 1'b1; par_err_n = 1'b1;
    check("R2 idle", 16'h0);

    // R9: accumulation across cycles
    bus_cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    bus_cycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R9 sticky", nb(0) | nb(2) | nb(8));

    // R10: clear and capture on the same edge
    bus_cycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R10 clear+capture", nb(1));
    do_clear();

    // R7: exact latency of sys_flt0
    @(negedge clk) sys_flt0 = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R7 not yet", 16'h0);
    @(negedge clk);
    check("R7 set", nb(7));
    do_clear();
    repeat (4) @(negedge clk);
    check("R7 held level", 16'h0);
    sys_flt0 = 1'b0;

    // R8: sys_flt1 sets a bit pair
    repeat (3) @(negedge clk);
    sys_flt1 = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 pair", nb(13) | nb(15));
    sys_flt1 = 1'b0;
    repeat (3) @(negedge clk);
    bus_cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R9 with async bits", nb(13) | nb(15) | nb(5));
    do_clear();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule